// File: doc/BRIEF.md
# NOR flash sector erase sequencer

This block drives an 8-bit parallel NOR flash through a multi-sector erase. A request names a start byte address and a byte length, both whole sectors of a fixed size. Once accepted, the block issues the six-write unlock-and-arm preamble and then one sector-erase command for each sector in the run, in ascending order. Between two sector commands it waits a configured number of clocks. After each sector command except the first, it reads the device status to confirm that the device is still accepting more sectors.

After the last sector command the block polls the device status byte at the start address. It keeps a short history of these reads. From the history it decides whether the erase completed or is still running. If it failed, it also decides why. It reports the result with a one-cycle done pulse, an error flag and a three-bit cause code. The bus is a simple synchronous one. A write strobe carries an address and a data byte. A read strobe carries an address, and the device returns the byte on the read-data input, where the block samples it one clock later.

Top module: `nor_erase_seq`

## Requirements
- R1: During reset and on the first cycle after it, busy, done, error, cause, the write strobe and the read strobe are all 0.
- R2: A start taken while idle is rejected if any of these holds: the address is not a multiple of the sector size, the length is not a multiple of the sector size, the length is zero, or address plus length exceeds 2^ADDR_W. On a rejection, done pulses on the cycle after start, error is 1, the cause is 1, and no bus access takes place.
- R3: An accepted request starts with six back-to-back writes in the cycles right after start. They are, in order: F0 to 555h, AA to 555h, 55 to 2AAh, 80 to 555h, AA to 555h, 55 to 2AAh.
- R4: Right after the preamble the block writes 30h to each sector address, from the start address upward in steps of the sector size. There is one write per sector in the request.
- R5: After each sector write except the first, the block issues one status read at that sector's address. If bit 3 of the returned byte is set, the block issues no further writes and finishes with cause 2.
- R6: The first pair of sector writes is spaced gap+2 cycles apart. Every later pair is spaced gap+4 cycles apart. A request is rejected with cause 1 if gap+4 exceeds WIN_CLKS.
- R7: Polling reads the start address. No verdict is drawn before the third poll read. Once three or more reads exist, a newest read with bit 7 set ends the operation successfully, with error 0 and cause 0.
- R8: If the newest poll read has bit 7 clear and equals the previous read, the erase has failed. The cause is 3 if bit 5 of the read before those two is set, and 4 otherwise.
- R9: If MAX_POLLS poll reads give neither success nor failure, the block finishes with cause 5. A verdict drawn on the last allowed read takes precedence.
- R10: Busy is high from the cycle after an accepted start until the cycle in which done pulses. Done lasts one cycle. Error and cause hold their values until the next accepted start, which clears them.
- R11: A start that arrives while busy is ignored. The bus sequence and the result of the running erase are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| sect_addr_i | input | ADDR_W | Start byte address of the run |
| len_i | input | ADDR_W+1 | Length of the run in bytes |
| gap_i | input | GAP_W | Extra wait clocks between sector commands |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation failed or was rejected |
| cause_o | output | 3 | 0 none, 1 bad request, 2 window closed, 3 device failure, 4 erase did not take, 5 poll timeout |
| fl_we_o | output | 1 | Flash write strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_rdata_i | input | 8 | Flash read data, sampled the cycle after a read strobe |

## Verification
The bench builds the block with a 12-bit address space and 256-byte sectors, so the device has sixteen sectors. Every start-sector and sector-count pair can then be swept, including zero length and every run that overflows the device. The window limit is 8 clocks and the gap input is 4 bits wide. With these values, every legal gap up to the limit is exercised and the first illegal one is rejected. The poll limit is 8 reads, which keeps the timeout, and the verdict that lands on the final allowed read, within a few dozen cycles.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_BAD_REQ  = 3'd1,
        CAUSE_WINDOW   = 3'd2,
        CAUSE_DEV_FAIL = 3'd3,
        CAUSE_NO_TAKE  = 3'd4,
        CAUSE_TIMEOUT  = 3'd5
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SECT,
        ST_CHK_RD,
        ST_CHK_EV,
        ST_GAP,
        ST_POLL_RD,
        ST_POLL_EV
    } state_e;

    typedef enum logic [1:0] {
        VERD_WAIT,
        VERD_OK,
        VERD_FAIL
    } verdict_e;

    localparam int          SETUP_LEN  = 6;
    localparam logic [7:0]  CMD_SECTOR = 8'h30;

    // unlock/arm preamble, the order is what the device decodes
    function automatic logic [11:0] setup_addr(input logic [2:0] step);
        return (step == 3'd2 || step == 3'd5) ? 12'h2AA : 12'h555;
    endfunction

    function automatic logic [7:0] setup_data(input logic [2:0] step);
        case (step)
            3'd0:    return 8'hF0;
            3'd1:    return 8'hAA;
            3'd2:    return 8'h55;
            3'd3:    return 8'h80;
            3'd4:    return 8'hAA;
            3'd5:    return 8'h55;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nfe_req_check.sv
module nfe_req_check #(
    parameter int ADDR_W     = 21,
    parameter int SECT_SHIFT = 16,
    parameter int GAP_W      = 8,
    parameter int WIN_CLKS   = 200,
    parameter int OVH        = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W:0]   len_i,
    input  logic [GAP_W-1:0]  gap_i,
    output logic              ok_o
);
    localparam int SUM_W = ADDR_W + 2;
    localparam logic [SUM_W-1:0] DEV_BYTES = SUM_W'(1) << ADDR_W;

    logic [SUM_W-1:0] end_w;
    logic             addr_al, len_al, len_nz, fits, gap_fits;

    always_comb begin
        end_w    = SUM_W'(addr_i) + SUM_W'(len_i);
        addr_al  = (addr_i[SECT_SHIFT-1:0] == '0);
        len_al   = (len_i[SECT_SHIFT-1:0] == '0);
        len_nz   = (len_i != '0);
        fits     = (end_w <= DEV_BYTES);
        gap_fits = ((32'(gap_i) + 32'(OVH)) <= 32'(WIN_CLKS));
        ok_o     = addr_al && len_al && len_nz && fits && gap_fits;
    end
endmodule

// File: rtl/nfe_status_judge.sv
module nfe_status_judge
    import nfe_pkg::*;
(
    input  logic [7:0] new_i,
    input  logic [7:0] prev_i,
    input  logic       older_b5_i,
    input  logic       ready_i,
    output verdict_e   verdict_o,
    output cause_e     cause_o
);
    always_comb begin
        verdict_o = VERD_WAIT;
        cause_o   = CAUSE_NONE;
        if (ready_i) begin
            if (new_i[7]) begin
                verdict_o = VERD_OK;
            end else if (new_i == prev_i) begin
                verdict_o = VERD_FAIL;
                cause_o   = older_b5_i ? CAUSE_DEV_FAIL : CAUSE_NO_TAKE;
            end
        end
    end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nfe_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int SECT_SHIFT = 16,
    parameter int GAP_W      = 8,
    parameter int WIN_CLKS   = 200,
    parameter int MAX_POLLS  = 65535
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] sect_addr_i,
    input  logic [ADDR_W:0]   len_i,
    input  logic [GAP_W-1:0]  gap_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        cause_o,
    output logic              fl_we_o,
    output logic              fl_rd_o,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic [7:0]        fl_wdata_o,
    input  logic [7:0]        fl_rdata_i
);
    localparam int CNT_W  = ADDR_W - SECT_SHIFT + 1;
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam int OVH    = 4;  // sector write, check read, check eval, one gap cycle
    localparam logic [ADDR_W-1:0] SECT_STEP = ADDR_W'(1) << SECT_SHIFT;

    typedef struct packed {
        state_e             st;
        logic [2:0]         idx;
        logic [ADDR_W-1:0]  addr;
        logic [ADDR_W-1:0]  base;
        logic [CNT_W-1:0]   left;
        logic               first;
        logic [GAP_W-1:0]   gap;
        logic [GAP_W-1:0]   gcnt;
        logic [7:0]         h1;
        logic               h2_b5;
        logic [POLL_W-1:0]  nrd;
        logic               done;
        logic               err;
        cause_e             cause;
    } regs_t;

    regs_t    q, d;
    logic     req_ok;
    verdict_e verdict;
    cause_e   judge_cause;

    nfe_req_check #(
        .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .GAP_W(GAP_W),
        .WIN_CLKS(WIN_CLKS), .OVH(OVH)
    ) i_req_check (
        .addr_i(sect_addr_i),
        .len_i (len_i),
        .gap_i (gap_i),
        .ok_o  (req_ok)
    );

    nfe_status_judge i_judge (
        .new_i     (fl_rdata_i),
        .prev_i    (q.h1),
        .older_b5_i(q.h2_b5),
        .ready_i   (q.nrd >= POLL_W'(2)),
        .verdict_o (verdict),
        .cause_o   (judge_cause)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (!req_ok) begin
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.cause = CAUSE_BAD_REQ;
                    end else begin
                        d.st    = ST_SETUP;
                        d.idx   = '0;
                        d.addr  = sect_addr_i;
                        d.base  = sect_addr_i;
                        d.left  = CNT_W'(len_i >> SECT_SHIFT);
                        d.first = 1'b1;
                        d.gap   = gap_i;
                        d.gcnt  = '0;
                        d.h1    = '0;
                        d.h2_b5 = 1'b0;
                        d.nrd   = '0;
                        d.err   = 1'b0;
                        d.cause = CAUSE_NONE;
                    end
                end
            end
            ST_SETUP: begin
                d.idx = q.idx + 3'd1;
                if (q.idx == 3'(SETUP_LEN - 1)) d.st = ST_SECT;
            end
            ST_SECT: begin
                d.left  = q.left - CNT_W'(1);
                d.first = 1'b0;
                d.gcnt  = '0;
                if (q.first) d.st = (q.left == CNT_W'(1)) ? ST_POLL_RD : ST_GAP;
                else         d.st = ST_CHK_RD;
            end
            ST_CHK_RD: d.st = ST_CHK_EV;
            ST_CHK_EV: begin
                if (fl_rdata_i[3]) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.cause = CAUSE_WINDOW;
                end else if (q.left == '0) begin
                    d.st = ST_POLL_RD;
                end else begin
                    d.st = ST_GAP;
                end
            end
            ST_GAP: begin
                if (q.gcnt == q.gap) begin
                    d.st   = ST_SECT;
                    d.addr = q.addr + SECT_STEP;
                end else begin
                    d.gcnt = q.gcnt + GAP_W'(1);
                end
            end
            ST_POLL_RD: d.st = ST_POLL_EV;
            ST_POLL_EV: begin
                d.h1    = fl_rdata_i;
                d.h2_b5 = q.h1[5];
                d.nrd   = q.nrd + POLL_W'(1);
                if (verdict == VERD_OK) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b0;
                    d.cause = CAUSE_NONE;
                end else if (verdict == VERD_FAIL) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.cause = judge_cause;
                end else if (q.nrd == POLL_W'(MAX_POLLS - 1)) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.err   = 1'b1;
                    d.cause = CAUSE_TIMEOUT;
                end else begin
                    d.st = ST_POLL_RD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            ST_SETUP:   fl_addr_o = ADDR_W'(setup_addr(q.idx));
            ST_POLL_RD: fl_addr_o = q.base;
            default:    fl_addr_o = q.addr;
        endcase
        case (q.st)
            ST_SETUP: fl_wdata_o = setup_data(q.idx);
            ST_SECT:  fl_wdata_o = CMD_SECTOR;
            default:  fl_wdata_o = 8'h00;
        endcase
    end

    assign busy_o  = (q.st != ST_IDLE);
    assign done_o  = q.done;
    assign err_o   = q.err;
    assign cause_o = q.cause;
    assign fl_we_o = (q.st == ST_SETUP) || (q.st == ST_SECT);
    assign fl_rd_o = (q.st == ST_CHK_RD) || (q.st == ST_POLL_RD);

endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
    parameter int WIN_CLKS = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy_o,
    input logic       done_o,
    input logic [2:0] cause_o,
    input logic       fl_we_o,
    input logic       fl_rd_o,
    input logic [7:0] fl_wdata_o
);
    localparam int CW = $clog2(WIN_CLKS + 2) + 1;

    logic [CW-1:0] since;
    logic          sect_wr;

    assign sect_wr = fl_we_o && (fl_wdata_o == 8'h30);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    since <= '0;
        else if (!busy_o)                              since <= '0;
        else if (sect_wr)                              since <= CW'(1);
        else if (since != '0 && since <= CW'(WIN_CLKS)) since <= since + CW'(1);
    end

    AST_GAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sect_wr && since != '0) |-> (since <= CW'(WIN_CLKS))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!fl_we_o && !fl_rd_o)); // R2

    AST_WE_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we_o && fl_rd_o)); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !fl_we_o && !fl_rd_o)); // R10

    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R10

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && $past(!busy_o)) |-> $stable(cause_o)); // R10

endmodule

bind nor_erase_seq nor_erase_seq_chk #(.WIN_CLKS(WIN_CLKS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .cause_o   (cause_o),
    .fl_we_o   (fl_we_o),
    .fl_rd_o   (fl_rd_o),
    .fl_wdata_o(fl_wdata_o)
);

// File: tb/test_nor_erase_seq.sv
module test_nor_erase_seq;
    localparam int AW = 12;
    localparam int SS = 8;
    localparam int GW = 4;
    localparam int WIN = 8;
    localparam int MP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a_i = '0;
    logic [AW:0]   l_i = '0;
    logic [GW-1:0] g_i = '0;
    logic          busy_o, done_o, err_o, fl_we_o, fl_rd_o;
    logic [2:0]    cause_o;
    logic [AW-1:0] fl_addr_o;
    logic [7:0]    fl_wdata_o;
    logic [7:0]    fl_rdata = 8'h00;

    always #5 clk = ~clk;

    nor_erase_seq #(
        .ADDR_W(AW), .SECT_SHIFT(SS), .GAP_W(GW), .WIN_CLKS(WIN), .MAX_POLLS(MP)
    ) i_nor_erase_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .sect_addr_i(a_i),
        .len_i(l_i), .gap_i(g_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .cause_o(cause_o), .fl_we_o(fl_we_o), .fl_rd_o(fl_rd_o),
        .fl_addr_o(fl_addr_o), .fl_wdata_o(fl_wdata_o), .fl_rdata_i(fl_rdata)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int wr_addr[64], wr_data[64], wr_cyc[64], rd_addr[64];
    logic [7:0] scr[64];
    int  wr_n = 0, rd_n = 0, sidx = 0, done_n = 0, done_cyc = 0;
    bit  clr_req = 1'b0;
    int  n_cmp = 0, n_bad = 0;
    int  st_cyc = 0;
    bit  busy1 = 1'b0;

    // flash model and bus log, all on the falling edge
    always @(negedge clk) begin
        if (clr_req) begin
            wr_n = 0; rd_n = 0; sidx = 0; done_n = 0;
        end else begin
            if (fl_we_o && wr_n < 64) begin
                wr_addr[wr_n] = int'(fl_addr_o);
                wr_data[wr_n] = int'(fl_wdata_o);
                wr_cyc[wr_n]  = cyc;
                wr_n++;
            end
            if (fl_rd_o && rd_n < 64) begin
                rd_addr[rd_n] = int'(fl_addr_o);
                fl_rdata = scr[sidx];
                sidx++;
                rd_n++;
            end
            if (done_o) begin
                done_n++;
                done_cyc = cyc;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_sa(input int i);
        return (i == 2 || i == 5) ? 'h2AA : 'h555;
    endfunction

    function automatic int exp_sd(input int i);
        case (i)
            0: return 'hF0;
            1: return 'hAA;
            2: return 'h55;
            3: return 'h80;
            4: return 'hAA;
            default: return 'h55;
        endcase
    endfunction

    task automatic zero_script();
        for (int i = 0; i < 64; i++) scr[i] = 8'h00;
    endtask

    task automatic fill_ok(input int nchk);
        zero_script();
        scr[nchk] = 8'h00; scr[nchk+1] = 8'h40; scr[nchk+2] = 8'h80;
    endtask

    task automatic run_op(input int a, input int l, input int g, input bit inject);
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk);
        @(negedge clk); clr_req = 1'b0;
        @(negedge clk);
        a_i = AW'(a); l_i = (AW+1)'(l); g_i = GW'(g); start = 1'b1; st_cyc = cyc;
        @(negedge clk);
        start = 1'b0; busy1 = busy_o;
        if (inject) begin
            repeat (3) @(negedge clk);
            start = 1'b1; a_i = '0; l_i = (AW+1)'(256); g_i = '0;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 3000 && done_n == 0; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_out(input string req, input int exp_cause);
        chk(done_n == 1, req, "done pulse count", done_n, 1);
        chk((int'(err_o) * 8 + int'(cause_o)) == ((exp_cause != 0 ? 8 : 0) + exp_cause),
            req, "err*8+cause", int'(err_o) * 8 + int'(cause_o),
            (exp_cause != 0 ? 8 : 0) + exp_cause);
    endtask

    task automatic chk_trace(input string req, input int s, input int nsw, input int g,
                             input int nchk, input int npoll);
        int  ea, ed, ec, act, exp;
        bit  bad;
        bad = 1'b0; act = 0; exp = 0;
        if (wr_n != 6 + nsw) begin
            bad = 1'b1; act = wr_n; exp = 6 + nsw;
        end else if (rd_n != nchk + npoll) begin
            bad = 1'b1; act = rd_n; exp = nchk + npoll;
        end else begin
            for (int i = 0; i < wr_n; i++) begin
                if (i < 6) begin
                    ea = exp_sa(i); ed = exp_sd(i); ec = st_cyc + 1 + i;
                end else begin
                    ea = (s + i - 6) << SS; ed = 'h30;
                    if (i == 6)      ec = st_cyc + 7;
                    else if (i == 7) ec = wr_cyc[i-1] + g + 2;
                    else             ec = wr_cyc[i-1] + g + 4;
                end
                if (!bad && wr_addr[i] != ea) begin bad = 1'b1; act = wr_addr[i]; exp = ea; end
                if (!bad && wr_data[i] != ed) begin bad = 1'b1; act = wr_data[i]; exp = ed; end
                if (!bad && wr_cyc[i] != ec)  begin bad = 1'b1; act = wr_cyc[i];  exp = ec; end
            end
            for (int i = 0; i < rd_n; i++) begin
                ea = (i < nchk) ? ((s + 1 + i) << SS) : (s << SS);
                if (!bad && rd_addr[i] != ea) begin bad = 1'b1; act = rd_addr[i]; exp = ea; end
            end
        end
        chk(!bad, req, "bus trace", act, exp);
    endtask

    initial begin
        zero_script();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, err_o, cause_o, fl_we_o, fl_rd_o} == '0, "R1",
            "outputs in reset", int'({busy_o, done_o, err_o, cause_o, fl_we_o, fl_rd_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy_o, done_o, err_o, cause_o, fl_we_o, fl_rd_o} == '0, "R1",
            "outputs after reset", int'({busy_o, done_o, err_o, cause_o, fl_we_o, fl_rd_o}), 0);

        // exhaustive sweep over start sector and sector count
        for (int s = 0; s < 16; s++) begin
            for (int n = 0; n <= 16; n++) begin
                int g;
                bit valid;
                g = (s + n) % 5;
                valid = (n >= 1) && (s + n <= 16);
                fill_ok(n > 0 ? n - 1 : 0);
                run_op(s << SS, n << SS, g, 1'b0);
                if (valid) begin
                    chk_out("R4 R7", 0);
                    chk_trace("R3 R4 R5 R6", s, n, g, n - 1, 3);
                    chk(busy1 == 1'b1, "R10", "busy after start", int'(busy1), 1);
                end else begin
                    chk_out("R2", 1);
                    chk(wr_n + rd_n == 0, "R2", "bus accesses on reject", wr_n + rd_n, 0);
                    chk(done_cyc == st_cyc + 1, "R2", "reject latency", done_cyc - st_cyc, 1);
                end
            end
        end

        // misaligned start, misaligned length
        run_op('h110, 256, 0, 1'b0);
        chk_out("R2", 1);
        chk(wr_n + rd_n == 0, "R2", "bus on misaligned start", wr_n + rd_n, 0);
        run_op('h200, 'h180, 0, 1'b0);
        chk_out("R2", 1);
        chk(wr_n + rd_n == 0, "R2", "bus on misaligned length", wr_n + rd_n, 0);

        // gap one above the window budget
        fill_ok(1);
        run_op(0, 2 << SS, WIN - 3, 1'b0);
        chk_out("R6", 1);
        chk(wr_n + rd_n == 0, "R6", "bus on gap too large", wr_n + rd_n, 0);

        // window closed after third sector
        zero_script(); scr[1] = 8'h08;
        run_op(2 << SS, 3 << SS, 1, 1'b0);
        chk_out("R5", 2);
        chk_trace("R5", 2, 3, 1, 2, 0);
        // window closed after second sector of four
        zero_script(); scr[0] = 8'h08;
        run_op(0, 4 << SS, 0, 1'b0);
        chk_out("R5", 2);
        chk_trace("R5", 0, 2, 0, 1, 0);

        // device failure flagged by bit 5 of the older read
        zero_script(); scr[0] = 8'h20; scr[1] = 8'h44; scr[2] = 8'h44;
        run_op(5 << SS, 1 << SS, 0, 1'b0);
        chk_out("R8", 3);
        chk_trace("R8", 5, 1, 0, 0, 3);
        repeat (5) @(negedge clk);
        chk(busy_o == 1'b0 && err_o == 1'b1 && cause_o == 3'd3, "R10", "result held",
            int'(cause_o), 3);

        // erase did not take
        zero_script(); scr[1] = 8'h00; scr[2] = 8'h11; scr[3] = 8'h11;
        run_op(9 << SS, 2 << SS, 2, 1'b0);
        chk_out("R8", 4);
        chk_trace("R8", 9, 2, 2, 1, 3);

        // equal pair before the third read gives no verdict
        zero_script(); scr[0] = 8'h11; scr[1] = 8'h11; scr[2] = 8'h51; scr[3] = 8'h51;
        run_op(3 << SS, 1 << SS, 0, 1'b0);
        chk_out("R7 R8", 4);
        chk_trace("R7", 3, 1, 0, 0, 4);

        // bit 7 on the first read is not a verdict
        zero_script(); scr[0] = 8'h80; scr[1] = 8'h00; scr[2] = 8'h40; scr[3] = 8'h80;
        run_op(7 << SS, 1 << SS, 0, 1'b0);
        chk_out("R7", 0);
        chk_trace("R7", 7, 1, 0, 0, 4);

        // poll timeout
        zero_script();
        for (int i = 0; i < MP; i++) scr[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
        run_op(1 << SS, 1 << SS, 0, 1'b0);
        chk_out("R9", 5);
        chk_trace("R9", 1, 1, 0, 0, MP);

        // success on the final allowed read
        zero_script();
        for (int i = 0; i < MP - 1; i++) scr[i] = (i % 2 == 1) ? 8'h40 : 8'h00;
        scr[MP-1] = 8'h80;
        run_op(1 << SS, 1 << SS, 0, 1'b0);
        chk_out("R9", 0);
        chk_trace("R9", 1, 1, 0, 0, MP);

        // start while busy is ignored
        fill_ok(2);
        run_op(4 << SS, 3 << SS, 2, 1'b1);
        chk_out("R11", 0);
        chk_trace("R11", 4, 3, 2, 2, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule